// File: doc/BRIEF.md
# Power-Command Current Reference Calculator

This block sits in the outer control layer of a grid-tied three-phase converter. It receives the grid voltage and line current, already transformed to the synchronous d/q frame. From these it produces three results: the measured real and reactive power, the d and q current references needed to deliver commanded real and reactive power, and a d/q terminal voltage reference. That reference already includes the drop across a series reactance that separates the converter terminal from a remote reference bus.

All quantities are signed two's-complement fixed point with `FRAC` fractional bits (Q8.8 at the defaults). A one-cycle `start` pulse captures every input. The block then multiplies at double width and runs two sequential signed dividers in parallel. It publishes all six results and the error flag together in the single cycle in which `done` is high. When the d-axis voltage magnitude is too small to divide by, the division is skipped, the previous current references are kept and `err` is set.

Top module: `power_ref_calc`

## Requirements
- R1: `pOut` = sat(floor(T / 2^8)), where S = vQ·iQ + vD·iD, T = S + floor(S/2), all values Q8.8, and floor is arithmetic shifting toward minus infinity.
- R2: `qOut` = sat(floor(T / 2^8)), where S = vQ·iD − vD·iQ and T = S + floor(S/2).
- R3: When a division is performed, `idRef` = sat(trunc((2·pCmd·2^8 − 3·vQ·iQ) / (3·vD))), with the quotient truncated toward zero.
- R4: When a division is performed, `iqRef` = sat(trunc((3·vQ·iD − 2·qCmd·2^8) / (3·vD))), with the quotient truncated toward zero.
- R5: `utQ` = sat(uSq + floor(xS·iSd / 2^8)) and `utD` = sat(uSd − floor(xS·iSq / 2^8)).
- R6: sat() clamps every output to the range −32768..32767 rather than wrapping.
- R7: When vD = 0 or |vD| < `vdMin`, `err` is 1 and `idRef`/`iqRef` keep their previous values, while R1, R2 and R5 outputs are still updated.
- R8: An operation that performs the division drives `err` to 0.
- R9: `done` is high for exactly one cycle per accepted `start`, and every output including `err` changes only in a cycle where `done` is high.
- R10: A `start` pulse that arrives while an operation is in progress is ignored: it produces no extra `done`, and the running result is unchanged.
- R11: After reset all data outputs, `err` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that captures inputs and begins an operation |
| vD | input | W | Grid voltage, d axis |
| vQ | input | W | Grid voltage, q axis |
| iD | input | W | Line current, d axis |
| iQ | input | W | Line current, q axis |
| iSd | input | W | Current through series reactance, d axis |
| iSq | input | W | Current through series reactance, q axis |
| uSd | input | W | Remote bus voltage, d axis |
| uSq | input | W | Remote bus voltage, q axis |
| pCmd | input | W | Real power command |
| qCmd | input | W | Reactive power command |
| xS | input | W | Series reactance |
| vdMin | input | W | Minimum allowed unsigned |vD| magnitude for the division |
| pOut | output | W | Measured real power |
| qOut | output | W | Measured reactive power |
| idRef | output | W | d-axis current reference |
| iqRef | output | W | q-axis current reference |
| utD | output | W | Terminal voltage reference, d axis |
| utQ | output | W | Terminal voltage reference, q axis |
| done | output | 1 | One-cycle pulse when all outputs are valid |
| err | output | 1 | Last operation skipped the division |

## Verification
The hardest condition to reach from the ports is a divider quotient that overflows the output width. That needs a dividend near its maximum paired with a d-axis voltage that only just passes the minimum check, so the stimulus sets `vdMin` to 1 and drives vD to a single LSB against a large power command. The hold path is reached by running a normal operation first, so that the held references are non-zero, and then a small-vD operation. Overlapping starts are produced by pulsing `start` again with different inputs a few cycles into a division, and the scoreboard then requires exactly one result, matching the first inputs.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef struct packed {
    logic capture;
    logic calc;
    logic divGo;
    logic skip;
    logic loadRefs;
    logic publish;
  } pcc_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_DECIDE,
    ST_DIV,
    ST_PUB
  } pcc_state_t;

endpackage

// File: rtl/pcc_divider.sv
module pcc_divider #(
  parameter int NW  = 35,
  parameter int DVW = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 go,
  input  logic signed [NW-1:0] dividend,
  input  logic signed [DVW-1:0] divisor,
  output logic signed [NW-1:0] quotient,
  output logic                 doneP
);
  localparam int CW = $clog2(NW + 1);

  logic [DVW-1:0] remR;
  logic [NW-1:0]  quoR;
  logic [DVW-1:0] dvsR;
  logic [CW-1:0]  cntR;
  logic           negR;
  logic           busyR;
  logic [DVW:0]   trial;

  assign trial    = {remR, quoR[NW-1]};
  assign quotient = negR ? -$signed(quoR) : $signed(quoR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      cntR  <= '0;
      negR  <= 1'b0;
      busyR <= 1'b0;
      doneP <= 1'b0;
    end else begin
      doneP <= 1'b0;
      if (go) begin
        quoR  <= dividend[NW-1] ? NW'(-dividend) : NW'(dividend);
        dvsR  <= divisor[DVW-1] ? DVW'(-divisor) : DVW'(divisor);
        negR  <= dividend[NW-1] ^ divisor[DVW-1];
        remR  <= '0;
        cntR  <= CW'(NW);
        busyR <= 1'b1;
      end else if (busyR) begin
        if (trial >= {1'b0, dvsR}) begin
          remR <= DVW'(trial - {1'b0, dvsR});
          quoR <= {quoR[NW-2:0], 1'b1};
        end else begin
          remR <= trial[DVW-1:0];
          quoR <= {quoR[NW-2:0], 1'b0};
        end
        cntR <= cntR - 1'b1;
        if (cntR == CW'(1)) begin
          busyR <= 1'b0;
          doneP <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        vdSmall,
  input  logic        divDone,
  output pcc_strobe_t strobe
);
  pcc_state_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        nextState      = ST_CALC;
      end
      ST_CALC: begin
        strobe.calc = 1'b1;
        nextState   = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (vdSmall) begin
          strobe.skip = 1'b1;
          nextState   = ST_PUB;
        end else begin
          strobe.divGo = 1'b1;
          nextState    = ST_DIV;
        end
      end
      ST_DIV: if (divDone) begin
        strobe.loadRefs = 1'b1;
        nextState       = ST_PUB;
      end
      ST_PUB: begin
        strobe.publish = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pcc_strobe_t         strobe,
  input  logic signed [W-1:0] vD, vQ, iD, iQ, iSd, iSq, uSd, uSq, pCmd, qCmd, xS,
  input  logic        [W-1:0] vdMin,
  output logic                vdSmall,
  output logic                divDone,
  output logic signed [W-1:0] pOut, qOut, idRef, iqRef, utD, utQ,
  output logic                done,
  output logic                err
);
  localparam int XW  = 2 * W + 4;
  localparam int NW  = 2 * W + 3;
  localparam int DVW = W + 2;
  localparam logic signed [XW-1:0] SAT_HI = XW'((2 ** (W - 1)) - 1);
  localparam logic signed [XW-1:0] SAT_LO = -SAT_HI - XW'(1);

  function automatic logic signed [XW-1:0] ext(input logic signed [W-1:0] v);
    return {{(XW - W){v[W-1]}}, v};
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [XW-1:0] x);
    if (x > SAT_HI)      return SAT_HI[W-1:0];
    else if (x < SAT_LO) return SAT_LO[W-1:0];
    else                 return x[W-1:0];
  endfunction

  logic signed [W-1:0] vdR, vqR, idR, iqR, isdR, isqR, usdR, usqR, pcR, qcR, xsR;
  logic        [W-1:0] vdMinR;
  logic signed [W-1:0] pStg, qStg, utdStg, utqStg, idStg, iqStg;
  logic                errStg;

  logic signed [XW-1:0] vqIq, vdId, vqId, vdIq, xsIsd, xsIsq, sumP, sumQ, absVd;
  assign vqIq  = ext(vqR) * ext(iqR);
  assign vdId  = ext(vdR) * ext(idR);
  assign vqId  = ext(vqR) * ext(idR);
  assign vdIq  = ext(vdR) * ext(iqR);
  assign xsIsd = ext(xsR) * ext(isdR);
  assign xsIsq = ext(xsR) * ext(isqR);
  assign sumP  = vqIq + vdId;
  assign sumQ  = vqId - vdIq;
  assign absVd = vdR[W-1] ? -ext(vdR) : ext(vdR);
  assign vdSmall = (vdR == '0) || (absVd < $signed({{(XW - W){1'b0}}, vdMinR}));

  logic signed [NW-1:0]  numR [2];
  logic signed [DVW-1:0] denR;
  logic signed [NW-1:0]  quot [2];
  logic [1:0]            axisDone;

  generate
    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
      pcc_divider #(.NW(NW), .DVW(DVW)) u_div (
        .clk     (clk),
        .rstN    (rstN),
        .go      (strobe.divGo),
        .dividend(numR[ax]),
        .divisor (denR),
        .quotient(quot[ax]),
        .doneP   (axisDone[ax])
      );
    end
  endgenerate
  assign divDone = axisDone[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {vdR, vqR, idR, iqR, isdR, isqR, usdR, usqR, pcR, qcR, xsR} <= '0;
      vdMinR <= '0;
      {pStg, qStg, utdStg, utqStg, idStg, iqStg} <= '0;
      errStg <= 1'b0;
      numR[0] <= '0;
      numR[1] <= '0;
      denR    <= '0;
      {pOut, qOut, idRef, iqRef, utD, utQ} <= '0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strobe.publish;
      if (strobe.capture) begin
        {vdR, vqR, idR, iqR, isdR, isqR, usdR, usqR, pcR, qcR, xsR}
          <= {vD, vQ, iD, iQ, iSd, iSq, uSd, uSq, pCmd, qCmd, xS};
        vdMinR <= vdMin;
      end
      if (strobe.calc) begin
        pStg    <= sat((sumP + (sumP >>> 1)) >>> FRAC);
        qStg    <= sat((sumQ + (sumQ >>> 1)) >>> FRAC);
        utqStg  <= sat(ext(usqR) + (xsIsd >>> FRAC));
        utdStg  <= sat(ext(usdR) - (xsIsq >>> FRAC));
        numR[0] <= NW'((ext(pcR) <<< (FRAC + 1)) - XW'(3) * vqIq);
        numR[1] <= NW'(XW'(3) * vqId - (ext(qcR) <<< (FRAC + 1)));
        denR    <= DVW'(XW'(3) * ext(vdR));
      end
      if (strobe.skip) errStg <= 1'b1;
      if (strobe.loadRefs) begin
        idStg  <= sat({{(XW - NW){quot[0][NW-1]}}, quot[0]});
        iqStg  <= sat({{(XW - NW){quot[1][NW-1]}}, quot[1]});
        errStg <= 1'b0;
      end
      if (strobe.publish) begin
        {pOut, qOut, idRef, iqRef, utD, utQ} <= {pStg, qStg, idStg, iqStg, utdStg, utqStg};
        err <= errStg;
      end
    end
  end
endmodule

// File: rtl/power_ref_calc.sv
module power_ref_calc
  import pcc_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] vD,
  input  logic signed [W-1:0] vQ,
  input  logic signed [W-1:0] iD,
  input  logic signed [W-1:0] iQ,
  input  logic signed [W-1:0] iSd,
  input  logic signed [W-1:0] iSq,
  input  logic signed [W-1:0] uSd,
  input  logic signed [W-1:0] uSq,
  input  logic signed [W-1:0] pCmd,
  input  logic signed [W-1:0] qCmd,
  input  logic signed [W-1:0] xS,
  input  logic        [W-1:0] vdMin,
  output logic signed [W-1:0] pOut,
  output logic signed [W-1:0] qOut,
  output logic signed [W-1:0] idRef,
  output logic signed [W-1:0] iqRef,
  output logic signed [W-1:0] utD,
  output logic signed [W-1:0] utQ,
  output logic                done,
  output logic                err
);
  pcc_strobe_t strobe;
  logic        vdSmall;
  logic        divDone;

  pcc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .vdSmall(vdSmall),
    .divDone(divDone),
    .strobe (strobe)
  );

  pcc_datapath #(.W(W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .vD(vD), .vQ(vQ), .iD(iD), .iQ(iQ), .iSd(iSd), .iSq(iSq),
    .uSd(uSd), .uSq(uSq), .pCmd(pCmd), .qCmd(qCmd), .xS(xS), .vdMin(vdMin),
    .vdSmall(vdSmall), .divDone(divDone),
    .pOut(pOut), .qOut(qOut), .idRef(idRef), .iqRef(iqRef), .utD(utD), .utQ(utQ),
    .done(done), .err(err)
  );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         done,
  input logic         err,
  input logic [W-1:0] pOut, qOut, idRef, iqRef, utD, utQ
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_OUTPUTS_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(pOut) && $stable(qOut) && $stable(utD) && $stable(utQ)
               && $stable(idRef) && $stable(iqRef))); // R9

  AST_ERR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(err)); // R9

  AST_REFS_HELD_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> ($stable(idRef) && $stable(iqRef))); // R7
endmodule

bind power_ref_calc pcc_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .err(err),
  .pOut(pOut), .qOut(qOut), .idRef(idRef), .iqRef(iqRef), .utD(utD), .utQ(utQ)
);

// File: tb/sim_power_ref_calc.sv
module sim_power_ref_calc;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    longint p, q, id, iq, utd, utq;
    bit     err;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [W-1:0] vD = '0, vQ = '0, iD = '0, iQ = '0, iSd = '0, iSq = '0;
  logic signed [W-1:0] uSd = '0, uSq = '0, pCmd = '0, qCmd = '0, xS = '0;
  logic        [W-1:0] vdMin = '0;
  logic signed [W-1:0] pOut, qOut, idRef, iqRef, utD, utQ;
  logic done, err;

  int checks = 0;
  int failures = 0;
  int pushes = 0;
  int doneSeen = 0;
  bit prevDone = 1'b0;
  bit ended = 1'b0;
  longint heldId = 0, heldIq = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  power_ref_calc u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .vD(vD), .vQ(vQ), .iD(iD), .iQ(iQ), .iSd(iSd), .iSq(iSq),
    .uSd(uSd), .uSq(uSq), .pCmd(pCmd), .qCmd(qCmd), .xS(xS), .vdMin(vdMin),
    .pOut(pOut), .qOut(qOut), .idRef(idRef), .iqRef(iqRef), .utD(utD), .utQ(utQ),
    .done(done), .err(err)
  );

  function automatic longint sat(longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic check(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: applies one operation and pushes its expected result
  task automatic runOp(longint vd, vq, id, iq, isd, isq, usd, usq, pc, qc, xs, vmin,
                       bit overlap);
    exp_t e;
    longint s, avd;
    @(negedge clk);
    vD = W'(vd); vQ = W'(vq); iD = W'(id); iQ = W'(iq); iSd = W'(isd); iSq = W'(isq);
    uSd = W'(usd); uSq = W'(usq); pCmd = W'(pc); qCmd = W'(qc); xS = W'(xs);
    vdMin = W'(vmin);
    s = vq * iq + vd * id;  e.p = sat((s + (s >>> 1)) >>> 8);
    s = vq * id - vd * iq;  e.q = sat((s + (s >>> 1)) >>> 8);
    e.utq = sat(usq + ((xs * isd) >>> 8));
    e.utd = sat(usd - ((xs * isq) >>> 8));
    avd = (vd < 0) ? -vd : vd;
    e.err = (vd == 0) || (avd < vmin);
    if (!e.err) begin
      heldId = sat((2 * pc * 256 - 3 * vq * iq) / (3 * vd));
      heldIq = sat((3 * vq * id - 2 * qc * 256) / (3 * vd));
    end
    e.id = heldId;
    e.iq = heldIq;
    expQ.push_back(e);
    pushes++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (overlap) begin
      repeat (6) @(negedge clk);
      vD = 16'sd100; vQ = 16'sd5000; pCmd = 16'sd9999; uSq = 16'sd1234;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops and compares when the design reports a result
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) begin
        checks++; failures++;
        $display("FAIL R9 done high two cycles actual=1 expected=0");
      end
      if (done) begin
        doneSeen++;
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R10 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check("R1 pOut", longint'(pOut), e.p);
          check("R2 qOut", longint'(qOut), e.q);
          check("R3 idRef", longint'(idRef), e.id);
          check("R4 iqRef", longint'(iqRef), e.iq);
          check("R5 utQ", longint'(utQ), e.utq);
          check("R5 utD", longint'(utD), e.utd);
          check("R7 R8 err", longint'(err), longint'(e.err));
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 pOut", longint'(pOut), 0);
    check("R11 idRef", longint'(idRef), 0);
    check("R11 utD", longint'(utD), 0);
    check("R11 done", longint'(done), 0);
    check("R11 err", longint'(err), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R5: nominal positive operating point
    runOp(256, 20, 300, -40, 310, -50, 250, 10, 400, 100, 26, 32, 0);
    // negative d-axis voltage and negative commands
    runOp(-300, -77, -512, 600, -120, 90, -260, 33, -700, -250, 51, 32, 0);
    // R7: |vD| below minimum, refs held, others updated
    runOp(20, 40, 100, 100, 200, 200, 100, 100, 500, 500, 30, 32, 0);
    // R7: vD zero with minimum 0
    runOp(0, 40, 120, 90, 64, 64, -100, 50, 300, 300, 20, 0, 0);
    // R8: valid op clears err
    runOp(240, -15, 260, 35, 100, 100, 240, 0, 350, -120, 40, 32, 0);
    // R6: saturation of power and of the divided reference (vD one LSB)
    runOp(1, 32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767, -32768, 32767, 1, 0);
    // R6: negative saturation
    runOp(-32768, 32767, 32767, -32768, 32767, 32767, -32768, 32767, -32768, 32767, 32767, 1, 0);
    // R10: start while busy is ignored
    runOp(270, 12, 200, -60, 150, -80, 255, 5, 420, 60, 33, 32, 1);
    repeat (60) @(negedge clk);
    check("R10 done count", longint'(doneSeen), longint'(pushes));
    check("R9 done low idle", longint'(done), 0);

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule